// File: doc/BRIEF.md
# Strapped Management Address with Frame Match

This block sets a transceiver's management address from three pins whose levels are read during reset. The same pins carry receive-side signals in normal operation. Both the power-on reset and the external active-low reset hold the block in reset. While either is low, the shared pins are released and their levels are sampled. When reset ends, the last sampled levels become the low three bits of a 5-bit address register, and the upper two bits are cleared. One clock later the pins go back to driving their receive-side signals.

After that, software can replace the whole 5-bit address through a write port, which allows addresses above 7. A frame decoder presents the address field of each management frame with a valid strobe. The block then returns a one-cycle match pulse when the field equals the held address. The held address is also supplied as the starting seed of a scrambler, so several devices on one board begin with different scrambler states.

Top module: `mgmt_strap_addr`

## Requirements
- R1: While `por_n` or `ext_rst_n` is low, the block is in reset. During reset `pad_oe` is 0, `match_o` is 0, frames are ignored and writes are ignored.
- R2: When reset ends, `scr_seed_o` takes the value {2'b00, pad_in} as sampled at the last rising clock edge before release. Bit 0 comes from the pin shared with receive-error, bit 1 from the pin shared with the receive clock, and bit 2 from the pin shared with receive data bit 3.
- R3: If all three strap pins are low during reset, the address after reset is 0.
- R4: All bits of `pad_oe` stay 0 throughout reset and through the first rising edge after release, and all three become 1 after the second rising edge. `pad_out` is 0 whenever `pad_oe` is 0.
- R5: While `pad_oe` is 1, `pad_out[0]`, `pad_out[1]` and `pad_out[2]` follow `rx_func_i[0]` (receive error), `rx_func_i[1]` (receive clock) and `rx_func_i[2]` (receive data bit 3).
- R6: When `pad_oe` is 1, a cycle with `wr_en_i` high loads all five bits of `wr_addr_i` at the next rising edge. Writes presented while `pad_oe` is 0 leave the address unchanged.
- R7: `match_o` is high for exactly the one cycle after a cycle in which `frm_valid_i` is high, `pad_oe` is 1, and `frm_addr_i` equals the held address. A write in the same cycle as a frame does not change the address that frame is compared against. No pulse is produced when `frm_valid_i` is low.
- R8: `scr_seed_o` always shows the held address.
- R9: A new reset discards any written address and recaptures the strap levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| pad_in | input | 3 | Levels read from the shared pins |
| rx_func_i | input | 3 | Receive-side values for the shared pins (bit0 error, bit1 clock, bit2 data 3) |
| pad_out | output | 3 | Values driven onto the shared pins |
| pad_oe | output | 3 | Output enables of the shared pins |
| wr_en_i | input | 1 | Address write strobe |
| wr_addr_i | input | 5 | Address value to write |
| frm_valid_i | input | 1 | Frame address field valid |
| frm_addr_i | input | 5 | Decoded frame address field |
| match_o | output | 1 | One-cycle address match pulse |
| scr_seed_o | output | 5 | Held address, used as the scrambler seed |

## Verification
A wrong captured or held address shows on `scr_seed_o` at the first negative clock edge after the faulty register update. It also shows one cycle after the next frame, as a missing or extra `match_o` pulse. A bad phase state shows as `pad_oe` rising a cycle early or late, or as frames and writes being taken while the pins are still released. Each of these appears within two cycles of reset release. A scoreboard checks every frame's pulse in the cycle it falls due and reports any pulse that was not expected.

// File: rtl/mgmt_strap_pkg.sv
`timescale 1ns/1ps
package mgmt_strap_pkg;

    localparam int STRAP_PINS = 3;
    localparam int MGMT_ADDR_W = 5;

    // Start-up phase after reset release.
    typedef enum logic [1:0] {
        PH_CAPTURE = 2'd0,
        PH_SETTLE  = 2'd1,
        PH_ACTIVE  = 2'd2
    } link_phase_e;

endpackage

// File: rtl/strap_sampler.sv
`timescale 1ns/1ps
module strap_sampler #(
    parameter int STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pad_in,
    output logic [STRAP_W-1:0] strap_o
);

    logic [STRAP_W-1:0] smp_d, smp_q;

    // Follow the pins only while reset is held; keep the last value afterwards.
    always_comb begin
        smp_d = smp_q;
        if (!rst_n) begin
            smp_d = pad_in;
        end
    end

    always_ff @(posedge clk) begin
        smp_q <= smp_d;
    end

    assign strap_o = smp_q;

endmodule

// File: rtl/mgmt_addr_ctrl.sv
`timescale 1ns/1ps
module mgmt_addr_ctrl
    import mgmt_strap_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    output link_phase_e        phase_o,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam int HI_W = ADDR_W - STRAP_W;

    typedef struct packed {
        link_phase_e       phase;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_CAPTURE: begin
                st_d.addr  = {{HI_W{1'b0}}, strap_i};
                st_d.phase = PH_SETTLE;
            end
            PH_SETTLE: begin
                st_d.phase = PH_ACTIVE;
            end
            PH_ACTIVE: begin
                if (wr_en_i) begin
                    st_d.addr = wr_addr_i;
                end
            end
            default: begin
                st_d.phase = PH_CAPTURE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_CAPTURE;
            st_q.addr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign addr_o  = st_q.addr;

endmodule

// File: rtl/frame_addr_match.sv
`timescale 1ns/1ps
module frame_addr_match #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              frm_valid_i,
    input  logic [ADDR_W-1:0] frm_addr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              match_o
);

    typedef struct packed {
        logic hit;
    } match_t;

    match_t m_d, m_q;

    always_comb begin
        m_d.hit = enable_i && frm_valid_i && (frm_addr_i == addr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign match_o = m_q.hit;

endmodule

// File: rtl/shared_pad_mux.sv
`timescale 1ns/1ps
module shared_pad_mux #(
    parameter int STRAP_W = 3
) (
    input  logic               drive_i,
    input  logic [STRAP_W-1:0] func_i,
    output logic [STRAP_W-1:0] pad_out,
    output logic [STRAP_W-1:0] pad_oe
);

    for (genvar gi = 0; gi < STRAP_W; gi++) begin : g_pin
        assign pad_oe[gi]  = drive_i;
        assign pad_out[gi] = drive_i & func_i[gi];
    end

endmodule

// File: rtl/mgmt_strap_addr.sv
`timescale 1ns/1ps
module mgmt_strap_addr
    import mgmt_strap_pkg::*;
#(
    parameter int STRAP_W = STRAP_PINS,
    parameter int ADDR_W  = MGMT_ADDR_W
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               ext_rst_n,
    input  logic [STRAP_W-1:0] pad_in,
    input  logic [STRAP_W-1:0] rx_func_i,
    output logic [STRAP_W-1:0] pad_out,
    output logic [STRAP_W-1:0] pad_oe,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic               frm_valid_i,
    input  logic [ADDR_W-1:0]  frm_addr_i,
    output logic               match_o,
    output logic [ADDR_W-1:0]  scr_seed_o
);

    logic               rst_n;
    logic [STRAP_W-1:0] strap;
    link_phase_e        phase;
    logic [ADDR_W-1:0]  addr;
    logic               active;

    assign rst_n  = por_n & ext_rst_n;
    assign active = (phase == PH_ACTIVE);

    strap_sampler #(.STRAP_W(STRAP_W)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .strap_o (strap)
    );

    mgmt_addr_ctrl #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .phase_o   (phase),
        .addr_o    (addr)
    );

    frame_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (active),
        .frm_valid_i (frm_valid_i),
        .frm_addr_i  (frm_addr_i),
        .addr_i      (addr),
        .match_o     (match_o)
    );

    shared_pad_mux #(.STRAP_W(STRAP_W)) u_pads (
        .drive_i (active),
        .func_i  (rx_func_i),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign scr_seed_o = addr;

endmodule

// File: rtl/mgmt_strap_addr_chk.sv
`timescale 1ns/1ps
module mgmt_strap_addr_chk #(
    parameter int STRAP_W = 3,
    parameter int ADDR_W  = 5
) (
    input logic               clk,
    input logic               por_n,
    input logic               ext_rst_n,
    input logic [STRAP_W-1:0] pad_oe,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic               frm_valid_i,
    input logic [ADDR_W-1:0]  frm_addr_i,
    input logic               match_o,
    input logic [ADDR_W-1:0]  scr_seed_o
);

    logic rst_n;
    assign rst_n = por_n & ext_rst_n;

    p_oe_uniform_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pad_oe) == 0) || ($countones(pad_oe) == STRAP_W));

    p_oe_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[0] |-> $past(rst_n, 2));

    p_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe[0]) |-> (scr_seed_o[ADDR_W-1:STRAP_W] == '0));

    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && pad_oe[0]) |=> (scr_seed_o == $past(wr_addr_i)));

    p_addr_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && pad_oe[0]) |=> $stable(scr_seed_o));

    p_match_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(frm_valid_i) && ($past(frm_addr_i) == $past(scr_seed_o))));

    p_quiet_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[0] |-> !match_o);

endmodule

bind mgmt_strap_addr mgmt_strap_addr_chk #(.STRAP_W(STRAP_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .ext_rst_n   (ext_rst_n),
    .pad_oe      (pad_oe),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .frm_valid_i (frm_valid_i),
    .frm_addr_i  (frm_addr_i),
    .match_o     (match_o),
    .scr_seed_o  (scr_seed_o)
);

// File: tb/mgmt_strap_addr_bench.sv
`timescale 1ns/1ps
module mgmt_strap_addr_bench;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic [2:0] pad_in = 3'b101;
    logic [2:0] rx_func_i = 3'b000;
    logic [2:0] pad_out;
    logic [2:0] pad_oe;
    logic       wr_en_i = 1'b0;
    logic [4:0] wr_addr_i = 5'd0;
    logic       frm_valid_i = 1'b0;
    logic [4:0] frm_addr_i = 5'd0;
    logic       match_o;
    logic [4:0] scr_seed_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int    due;
        logic  exp;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    mgmt_strap_addr u_mgmt_strap_addr (
        .clk         (clk),
        .por_n       (por_n),
        .ext_rst_n   (ext_rst_n),
        .pad_in      (pad_in),
        .rx_func_i   (rx_func_i),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .frm_valid_i (frm_valid_i),
        .frm_addr_i  (frm_addr_i),
        .match_o     (match_o),
        .scr_seed_o  (scr_seed_o)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: one frame strobe, expected pulse queued for the next cycle.
    task automatic send_frame(logic [4:0] a, logic v, logic exp, string tag);
        frm_valid_i = v;
        frm_addr_i  = a;
        exp_q.push_back('{due: cyc + 1, exp: exp, tag: tag});
        step();
        frm_valid_i = 1'b0;
    endtask

    // Monitor: compare each due item; any unexpected pulse is an error.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, {31'd0, match_o}, {31'd0, e.exp});
        end else if (cyc > 0 && match_o !== 1'b0) begin
            checks++;
            errors++;
            $display("FAIL R7 unexpected pulse: got %b expected 0", match_o);
        end
    end

    initial begin
        #(5.0 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rx_func_i = 3'b111;
        step(4);
        chk("R1 reset oe", pad_oe, 3'b000);
        chk("R4 reset pad_out", pad_out, 3'b000);
        chk("R1 reset match", match_o, 1'b0);

        // Power-on release with straps 101.
        por_n = 1'b1;
        step();
        chk("R4 oe low first edge", pad_oe, 3'b000);
        chk("R2 captured 101", scr_seed_o, 5'd5);
        step();
        chk("R4 oe high second edge", pad_oe, 3'b111);
        rx_func_i = 3'b001;
        #1;
        chk("R5 pad_out 001", pad_out, 3'b001);
        rx_func_i = 3'b110;
        #1;
        chk("R5 pad_out 110", pad_out, 3'b110);
        step();

        send_frame(5'd5, 1'b1, 1'b1, "R7 match strap addr");
        send_frame(5'd4, 1'b1, 1'b0, "R7 mismatch low bit");
        send_frame(5'd13, 1'b1, 1'b0, "R7 mismatch upper bits");
        send_frame(5'd5, 1'b0, 1'b0, "R7 no strobe");

        // Write together with a frame against the old address.
        wr_en_i = 1'b1;
        wr_addr_i = 5'd22;
        send_frame(5'd5, 1'b1, 1'b1, "R7 old addr during write");
        wr_en_i = 1'b0;
        chk("R6 write 22", scr_seed_o, 5'd22);
        chk("R8 seed follows write", scr_seed_o, 5'd22);
        send_frame(5'd22, 1'b1, 1'b1, "R7 match written addr");
        send_frame(5'd5, 1'b1, 1'b0, "R7 old addr no longer matches");

        // External reset with new straps; writes and frames ignored.
        pad_in = 3'b010;
        ext_rst_n = 1'b0;
        wr_en_i = 1'b1;
        wr_addr_i = 5'd31;
        send_frame(5'd22, 1'b1, 1'b0, "R1 frame in reset");
        step();
        chk("R1 ext reset oe", pad_oe, 3'b000);
        wr_en_i = 1'b0;
        ext_rst_n = 1'b1;
        step();
        chk("R9 recaptured 010", scr_seed_o, 5'd2);
        step();
        send_frame(5'd22, 1'b1, 1'b0, "R9 written addr dropped");
        send_frame(5'd2, 1'b1, 1'b1, "R9 match new strap");

        // Default straps low; write while pins still released.
        pad_in = 3'b000;
        por_n = 1'b0;
        step(3);
        por_n = 1'b1;
        wr_en_i = 1'b1;
        wr_addr_i = 5'd31;
        step(2);
        wr_en_i = 1'b0;
        chk("R3 default address", scr_seed_o, 5'd0);
        chk("R6 write ignored before oe", scr_seed_o, 5'd0);
        step();
        send_frame(5'd0, 1'b1, 1'b1, "R3 match address 0");
        step(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule